// File: doc/BRIEF.md
# Accumulator Datapath with a Single Shared Bus

This block is the register-transfer half of a small 8-bit accumulator machine. It holds a 32-word by 8-bit main store, a 5-bit program counter, a memory address register, a memory data register, an instruction register, an accumulator, a four-function arithmetic unit and a two-flag condition register. Every transfer between units goes over one internal 8-bit bus. The bus is built as a multiplexer selected by one drive input per source. It is not built from three-state buffers.

The datapath makes no sequencing decisions of its own. An external controller asserts bus-drive, register-load, store read/write and ALU-function inputs, and each transfer takes place on the rising clock edge while its enable is high. The opcode field of the instruction register and the zero and carry flags come out as outputs for that controller. The bus value also comes out, so the controller or a test environment can read any source register by driving it. A separate load port writes words into the store before a program runs.

Top module: `acc_bus_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, address register, data register, instruction register, accumulator and both flags on the next rising edge. The store contents are left as they were.
- R2: `bus_out` carries the value of the single source whose drive input is high. The sources are `drv_pc`, `drv_mdr`, `drv_opnd` and `drv_acc`. The program counter and the operand field (instruction bits 4:0) are zero-extended to 8 bits. When no source drives, the bus reads 0.
- R3: `bus_conflict` is high in any cycle in which two or more drive inputs are high, and low otherwise.
- R4: `ld_mar` loads bus bits 4:0 into the address register. `mem_rd` loads the store word at that address into the data register. `ld_mdr` loads the bus into the data register. When `mem_rd` and `ld_mdr` are both high, `mem_rd` wins.
- R5: `mem_wr` writes the data register into the store word at the address register. `load_en` writes `load_data` at `load_addr`. When both are high in one cycle, only the load-port write takes place.
- R6: `ld_ir` loads the bus into the instruction register. `opcode` shows instruction bits 7:5, and the 5-bit operand occupies bits 4:0.
- R7: `pc_inc` adds one to the program counter, and 31 wraps to 0. `ld_pc` loads bus bits 4:0 and takes priority over `pc_inc`.
- R8: `alu_wr` writes the ALU result into the accumulator. `alu_fn` selects the function: 00 gives zero, 01 gives accumulator minus one, 10 gives accumulator plus one, and 11 gives accumulator plus the bus. `ld_acc` copies the bus into the accumulator unchanged, and `alu_wr` wins if both are high.
- R9: The flags change only on `alu_wr`. Zero is set when the 8-bit result is 0. Carry is the carry out of plus-one and add, the borrow of minus-one (set when the accumulator was 0), and 0 for the zero function.
- R10: Transfers enabled on the same edge all take effect together, each using the values present before that edge. For example, loading the instruction register from the data register can share an edge with the program counter increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load-port write strobe for the store |
| load_addr | input | 5 | Load-port word address |
| load_data | input | 8 | Load-port write data |
| drv_pc | input | 1 | Program counter drives the bus |
| drv_mdr | input | 1 | Data register drives the bus |
| drv_opnd | input | 1 | Instruction operand field drives the bus |
| drv_acc | input | 1 | Accumulator drives the bus |
| ld_mar | input | 1 | Address register loads from the bus |
| ld_mdr | input | 1 | Data register loads from the bus |
| mem_rd | input | 1 | Data register loads the store word at the address register |
| mem_wr | input | 1 | Store word at the address register takes the data register |
| ld_ir | input | 1 | Instruction register loads from the bus |
| ld_pc | input | 1 | Program counter loads from the bus |
| pc_inc | input | 1 | Program counter increments |
| ld_acc | input | 1 | Accumulator loads the bus unchanged |
| alu_wr | input | 1 | Accumulator and flags take the ALU result |
| alu_fn | input | 2 | ALU function select |
| bus_out | output | 8 | Current shared-bus value |
| opcode | output | 3 | Instruction register bits 7:5 |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry/borrow flag |
| bus_conflict | output | 1 | More than one bus source enabled |

## Verification
The case that gets the most attention is two functions landing on one edge. The main pair is the program counter increment and a bus transfer into the instruction register, which happen together in the fetch's last step. The bench provokes this by raising `drv_mdr`, `ld_ir` and `pc_inc` in the same cycle. It then judges both effects afterwards: the opcode must come from the old data register, and the program counter, read back over the bus, must be exactly one higher. The same approach covers the priority pairs (store read against bus load of the data register, counter load against increment, ALU write against plain accumulator load, load port against store write). In each case both enables are raised together and the surviving value is read back through the bus.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

   typedef enum logic [1:0] {
      FN_ZERO = 2'b00,
      FN_DEC  = 2'b01,
      FN_INC  = 2'b10,
      FN_ADD  = 2'b11
   } alu_fn_e;

   localparam int NSRC     = 4;
   localparam int SRC_PC   = 0;
   localparam int SRC_MDR  = 1;
   localparam int SRC_OPND = 2;
   localparam int SRC_ACC  = 3;

endpackage

// File: rtl/acc_dp_store.sv
module acc_dp_store #(
   parameter int DW = 8,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (ld_en) begin
         words[ld_addr] <= ld_data;
      end else if (wr_en) begin
         words[wr_addr] <= wr_data;
      end
   end

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/acc_dp_busmux.sv
module acc_dp_busmux #(
   parameter int N = 4,
   parameter int W = 8
) (
   input  logic [N-1:0]        sel,
   input  logic [N-1:0][W-1:0] din,
   output logic [W-1:0]        dout,
   output logic                conflict
);
   logic [N-1:0][W-1:0] gated;

   generate
      for (genvar g = 0; g < N; g++) begin : g_lane
         assign gated[g] = sel[g] ? din[g] : '0;
      end
   endgenerate

   always_comb begin
      logic seen;
      dout     = '0;
      seen     = 1'b0;
      conflict = 1'b0;
      for (int i = 0; i < N; i++) begin
         dout = dout | gated[i];
         if (sel[i]) begin
            if (seen) conflict = 1'b1;
            seen = 1'b1;
         end
      end
   end

endmodule

// File: rtl/acc_dp_alu.sv
module acc_dp_alu
   import acc_dp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [1:0]    fn,
   output logic [DW-1:0] y,
   output logic          cy,
   output logic          zero
);
   logic [DW:0] wide;

   always_comb begin
      case (alu_fn_e'(fn))
         FN_ZERO: wide = '0;
         FN_DEC:  wide = {1'b0, a} - (DW+1)'(1);
         FN_INC:  wide = {1'b0, a} + (DW+1)'(1);
         default: wide = {1'b0, a} + {1'b0, b};
      endcase
   end

   assign y    = wide[DW-1:0];
   assign cy   = wide[DW];
   assign zero = (wide[DW-1:0] == '0);

endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
   import acc_dp_pkg::*;
#(
   parameter int DW  = 8,
   parameter int AW  = 5,
   parameter int OPW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_en,
   input  logic [AW-1:0] load_addr,
   input  logic [DW-1:0] load_data,
   input  logic          drv_pc,
   input  logic          drv_mdr,
   input  logic          drv_opnd,
   input  logic          drv_acc,
   input  logic          ld_mar,
   input  logic          ld_mdr,
   input  logic          mem_rd,
   input  logic          mem_wr,
   input  logic          ld_ir,
   input  logic          ld_pc,
   input  logic          pc_inc,
   input  logic          ld_acc,
   input  logic          alu_wr,
   input  logic [1:0]    alu_fn,
   output logic [DW-1:0] bus_out,
   output logic [OPW-1:0] opcode,
   output logic          flag_z,
   output logic          flag_c,
   output logic          bus_conflict
);
   localparam int OPNDW = DW - OPW;

   generate
      if (OPW + AW != DW) begin : g_bad_split
         $error("opcode and operand widths must fill the word exactly");
      end
      if (AW < 1 || OPW < 1) begin : g_bad_width
         $error("address and opcode widths must be positive");
      end
   endgenerate

   logic [AW-1:0] pc_q, mar_q;
   logic [DW-1:0] mdr_q, ir_q, acc_q;
   logic          z_q, c_q;

   logic [NSRC-1:0]         src_sel;
   logic [NSRC-1:0][DW-1:0] src_val;
   logic [DW-1:0]           bus;
   logic                    conflict;
   logic [DW-1:0]           store_rd;
   logic [DW-1:0]           alu_y;
   logic                    alu_cy, alu_zero;

   always_comb begin
      src_sel           = '0;
      src_sel[SRC_PC]   = drv_pc;
      src_sel[SRC_MDR]  = drv_mdr;
      src_sel[SRC_OPND] = drv_opnd;
      src_sel[SRC_ACC]  = drv_acc;
      src_val           = '0;
      src_val[SRC_PC]   = DW'(pc_q);
      src_val[SRC_MDR]  = mdr_q;
      src_val[SRC_OPND] = DW'(ir_q[OPNDW-1:0]);
      src_val[SRC_ACC]  = acc_q;
   end

   acc_dp_busmux #(.N(NSRC), .W(DW)) u_bus (
      .sel      (src_sel),
      .din      (src_val),
      .dout     (bus),
      .conflict (conflict)
   );

   acc_dp_store #(.DW(DW), .AW(AW)) u_store (
      .clk     (clk),
      .ld_en   (load_en),
      .ld_addr (load_addr),
      .ld_data (load_data),
      .wr_en   (mem_wr),
      .wr_addr (mar_q),
      .wr_data (mdr_q),
      .rd_addr (mar_q),
      .rd_data (store_rd)
   );

   acc_dp_alu #(.DW(DW)) u_alu (
      .a    (acc_q),
      .b    (bus),
      .fn   (alu_fn),
      .y    (alu_y),
      .cy   (alu_cy),
      .zero (alu_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         mar_q <= '0;
      end else begin
         if (ld_mar) mar_q <= bus[AW-1:0];
         if (ld_pc) begin
            pc_q <= bus[AW-1:0];
         end else if (pc_inc) begin
            pc_q <= pc_q + AW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mdr_q <= '0;
         ir_q  <= '0;
      end else begin
         if (mem_rd) begin
            mdr_q <= store_rd;
         end else if (ld_mdr) begin
            mdr_q <= bus;
         end
         if (ld_ir) ir_q <= bus;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         z_q   <= 1'b0;
         c_q   <= 1'b0;
      end else if (alu_wr) begin
         acc_q <= alu_y;
         z_q   <= alu_zero;
         c_q   <= alu_cy;
      end else if (ld_acc) begin
         acc_q <= bus;
      end
   end

   assign bus_out      = bus;
   assign opcode       = ir_q[DW-1 -: OPW];
   assign flag_z       = z_q;
   assign flag_c       = c_q;
   assign bus_conflict = conflict;

endmodule

// File: rtl/acc_dp_checker.sv
module acc_dp_checker #(
   parameter int DW  = 8,
   parameter int AW  = 5,
   parameter int OPW = 3
) (
   input logic           clk,
   input logic           rst,
   input logic [3:0]     drv,
   input logic [DW-1:0]  bus,
   input logic           conflict,
   input logic           ld_mar,
   input logic [AW-1:0]  mar,
   input logic           ld_ir,
   input logic [OPW-1:0] opcode,
   input logic           ld_pc,
   input logic           pc_inc,
   input logic [AW-1:0]  pc,
   input logic           alu_wr,
   input logic [DW-1:0]  acc,
   input logic           fz,
   input logic           fc
);

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (pc == '0 && acc == '0 && opcode == '0 && !fz && !fc));

   assert_conflict_flag_R3: assert property (@(posedge clk) disable iff (rst)
      ($countones(drv) > 1) == conflict);

   assert_mar_capture_R4: assert property (@(posedge clk) disable iff (rst)
      ld_mar |=> mar == $past(bus[AW-1:0]));

   assert_ir_capture_R6: assert property (@(posedge clk) disable iff (rst)
      ld_ir |=> opcode == $past(bus[DW-1 -: OPW]));

   assert_pc_load_R7: assert property (@(posedge clk) disable iff (rst)
      ld_pc |=> pc == $past(bus[AW-1:0]));

   assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
      (pc_inc && !ld_pc) |=> pc == AW'($past(pc) + AW'(1)));

   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !alu_wr |=> $stable({fz, fc}));

endmodule

bind acc_bus_datapath acc_dp_checker #(.DW(DW), .AW(AW), .OPW(OPW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .drv      ({drv_acc, drv_opnd, drv_mdr, drv_pc}),
   .bus      (bus),
   .conflict (bus_conflict),
   .ld_mar   (ld_mar),
   .mar      (mar_q),
   .ld_ir    (ld_ir),
   .opcode   (opcode),
   .ld_pc    (ld_pc),
   .pc_inc   (pc_inc),
   .pc       (pc_q),
   .alu_wr   (alu_wr),
   .acc      (acc_q),
   .fz       (flag_z),
   .fc       (flag_c)
);

// File: tb/acc_bus_datapath_tb_top.sv
module acc_bus_datapath_tb_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load_en = 1'b0;
   logic [4:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic drv_pc = 0, drv_mdr = 0, drv_opnd = 0, drv_acc = 0;
   logic ld_mar = 0, ld_mdr = 0, mem_rd = 0, mem_wr = 0, ld_ir = 0;
   logic ld_pc = 0, pc_inc = 0, ld_acc = 0, alu_wr = 0;
   logic [1:0] alu_fn = '0;
   logic [7:0] bus_out;
   logic [2:0] opcode;
   logic flag_z, flag_c, bus_conflict;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   typedef struct {
      int         what;   // 0 bus, 1 opcode, 2 zero, 3 carry, 4 conflict
      logic [7:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t sb[$];

   always #10 clk = ~clk;   // 50 MHz

   acc_bus_datapath dut_i (
      .clk(clk), .rst(rst),
      .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
      .drv_pc(drv_pc), .drv_mdr(drv_mdr), .drv_opnd(drv_opnd), .drv_acc(drv_acc),
      .ld_mar(ld_mar), .ld_mdr(ld_mdr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .ld_ir(ld_ir), .ld_pc(ld_pc), .pc_inc(pc_inc), .ld_acc(ld_acc),
      .alu_wr(alu_wr), .alu_fn(alu_fn),
      .bus_out(bus_out), .opcode(opcode), .flag_z(flag_z), .flag_c(flag_c),
      .bus_conflict(bus_conflict)
   );

   // monitor: pops expected items and compares against the live outputs
   initial begin
      forever begin
         sb_item_t it;
         logic [7:0] act;
         wait (sb.size() != 0);
         it = sb.pop_front();
         case (it.what)
            0: act = bus_out;
            1: act = {5'b0, opcode};
            2: act = {7'b0, flag_z};
            3: act = {7'b0, flag_c};
            default: act = {7'b0, bus_conflict};
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_sig(input int what, input logic [7:0] exp, input string tag);
      sb_item_t it;
      it.what = what;
      it.exp  = exp;
      it.tag  = tag;
      sb.push_back(it);
      #1;
   endtask

   task automatic clr_ctl();
      drv_pc = 0; drv_mdr = 0; drv_opnd = 0; drv_acc = 0;
      ld_mar = 0; ld_mdr = 0; mem_rd = 0; mem_wr = 0; ld_ir = 0;
      ld_pc = 0; pc_inc = 0; ld_acc = 0; alu_wr = 0; alu_fn = '0;
      load_en = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      clr_ctl();
   endtask

   // src: 0 pc, 1 mdr, 2 operand, 3 acc
   task automatic peek(input int src, input logic [7:0] exp, input string tag);
      case (src)
         0: drv_pc = 1;
         1: drv_mdr = 1;
         2: drv_opnd = 1;
         default: drv_acc = 1;
      endcase
      #2;
      expect_sig(0, exp, tag);
      drv_pc = 0; drv_mdr = 0; drv_opnd = 0; drv_acc = 0;
   endtask

   task automatic fetch();
      drv_pc = 1; ld_mar = 1; tick();
      mem_rd = 1; tick();
      drv_mdr = 1; ld_ir = 1; pc_inc = 1; tick();
   endtask

   task automatic alu_step(input logic [1:0] fn);
      alu_fn = fn; alu_wr = 1; tick();
   endtask

   task automatic preload(input logic [4:0] a, input logic [7:0] d);
      load_en = 1; load_addr = a; load_data = d; tick();
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      clr_ctl();
      tick();
      preload(5'd0, 8'h48);   // opcode 2, operand 8
      preload(5'd1, 8'hC5);   // opcode 6, operand 5
      preload(5'd2, 8'h3F);   // opcode 1, operand 31
      preload(5'd5, 8'h11);
      preload(5'd31, 8'hA3);
      rst = 0;

      // R1 reset state
      peek(0, 8'h00, "R1 pc after reset");
      peek(1, 8'h00, "R1 mdr after reset");
      peek(3, 8'h00, "R1 acc after reset");
      expect_sig(1, 8'h00, "R1 opcode after reset");
      expect_sig(2, 8'h00, "R1 zero flag after reset");
      expect_sig(3, 8'h00, "R1 carry flag after reset");
      tick();

      // R10 fetch with ir load and pc increment on the same edge
      fetch();
      expect_sig(1, 8'h02, "R6 R10 opcode after fetch");
      peek(2, 8'h08, "R6 operand field zero-extended");
      peek(0, 8'h01, "R7 R10 pc advanced during ir load");
      peek(1, 8'h48, "R4 mdr holds fetched word");
      tick();

      // R2/R3 bus behaviour
      #2; expect_sig(0, 8'h00, "R2 idle bus reads zero");
      expect_sig(4, 8'h00, "R3 no conflict when idle");
      drv_pc = 1; drv_acc = 1; #2;
      expect_sig(4, 8'h01, "R3 conflict with two drivers");
      drv_pc = 0; drv_acc = 0;
      drv_mdr = 1; #2;
      expect_sig(4, 8'h00, "R3 single driver no conflict");
      expect_sig(0, 8'h48, "R2 mdr value on bus");
      drv_mdr = 0;
      tick();

      // R8/R9 ALU functions
      drv_opnd = 1; alu_step(2'b11);
      peek(3, 8'h08, "R8 add immediate");
      expect_sig(2, 8'h00, "R9 zero clear after add");
      alu_step(2'b10);
      peek(3, 8'h09, "R8 increment");
      alu_step(2'b01);
      peek(3, 8'h08, "R8 decrement");
      alu_step(2'b00);
      peek(3, 8'h00, "R8 clear");
      expect_sig(2, 8'h01, "R9 zero set by clear");
      expect_sig(3, 8'h00, "R9 carry zero on clear");
      alu_step(2'b01);
      peek(3, 8'hFF, "R8 decrement from zero");
      expect_sig(3, 8'h01, "R9 borrow on decrement of zero");
      expect_sig(2, 8'h00, "R9 zero clear after borrow");
      alu_step(2'b10);
      peek(3, 8'h00, "R8 increment wraps");
      expect_sig(2, 8'h01, "R9 zero after wrap");
      expect_sig(3, 8'h01, "R9 carry out of increment");
      drv_mdr = 1; ld_acc = 1; tick();
      peek(3, 8'h48, "R8 plain accumulator load");
      expect_sig(2, 8'h01, "R9 zero held on plain load");
      expect_sig(3, 8'h01, "R9 carry held on plain load");
      drv_mdr = 1; ld_acc = 1; alu_step(2'b10);
      peek(3, 8'h49, "R8 alu write beats plain load");
      expect_sig(3, 8'h00, "R9 carry updated by alu write");
      tick();

      // R4 store read, data register priority
      fetch();
      expect_sig(1, 8'h06, "R6 second opcode");
      drv_opnd = 1; ld_mar = 1; tick();
      mem_rd = 1; tick();
      peek(1, 8'h11, "R4 store read via address register");
      mem_rd = 1; ld_mdr = 1; drv_acc = 1; tick();
      peek(1, 8'h11, "R4 store read beats bus load");
      ld_mdr = 1; drv_acc = 1; tick();
      peek(1, 8'h49, "R4 bus load into data register");
      tick();

      // R7 pc load and wrap
      fetch();
      peek(2, 8'h1F, "R6 operand 31");
      peek(0, 8'h03, "R7 pc after third fetch");
      drv_opnd = 1; ld_pc = 1; tick();
      peek(0, 8'h1F, "R7 pc loaded from bus");
      pc_inc = 1; tick();
      peek(0, 8'h00, "R7 pc wraps from 31");
      drv_opnd = 1; ld_pc = 1; pc_inc = 1; tick();
      peek(0, 8'h1F, "R7 load beats increment");
      tick();

      // R5 store write and load-port priority
      drv_opnd = 1; ld_mar = 1; tick();
      ld_mdr = 1; drv_acc = 1; tick();
      mem_wr = 1; tick();
      ld_mdr = 1; drv_opnd = 1; tick();
      peek(1, 8'h1F, "R4 data register overwritten");
      mem_rd = 1; tick();
      peek(1, 8'h49, "R5 store write of data register");
      load_en = 1; load_addr = 5'd31; load_data = 8'h77; mem_wr = 1; tick();
      mem_rd = 1; tick();
      peek(1, 8'h77, "R5 load port beats store write");
      tick();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule